// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an up-counting timer whose count restarts when it reaches a programmed period value, not when it overflows. Its input rate is the system clock reduced to an instruction-rate tick, then further reduced by a prescaler with three ratios. Each time the counter reaches the period value and then advances, the counter returns to zero and a one-cycle match pulse appears on a dedicated output. That output can serve a PWM generator as its time base or a serial port as its shift clock.

The match pulses also drive a postscaler with sixteen ratios. When the postscaler completes its count, it sets a sticky interrupt flag. An enable bit gates that flag onto the interrupt request output. Software reaches the counter, the period value, a control byte and the flag/enable byte through a small synchronous register port with a combinational read path.

Top module: `pm_timer`

## Requirements
- R1: After reset the counter reads 0, the period reads 0xFF, the control byte reads 0, the flag/enable byte reads 0, and both `period_match_o` and `irq_o` are low.
- R2: Register select `bus_addr` chooses among four registers. 0 is the counter, 1 is the period and 2 is the control byte. In the control byte, bit 7 always reads 0, bits 6:3 hold the postscale select, bit 2 is the run bit and bits 1:0 hold the prescale select. 3 is the interrupt byte: bit 0 is the flag, bit 1 is the enable, and the other bits read 0.
- R3: While running, the counter advances once every INSTR_DIV × P system cycles. P is 1 for prescale select 0, 4 for select 1, and 16 for select 2 or 3.
- R4: Suppose the counter equals the period when it is due to advance. Then it becomes 0 and `period_match_o` is high for exactly one cycle. With the counter at 0, the first match comes exactly INSTR_DIV × P × (period+1) cycles after the control write, and later matches keep that same spacing.
- R5: When the counter starts above the period, it counts up through its all-ones value, wraps to 0 with no match, and then matches when it reaches the period.
- R6: With postscale select S, the flag sets on every (S+1)-th match pulse, one cycle after that pulse.
- R7: Once set, the flag stays set until software writes 0 to it. A hardware set in the same cycle as a software write takes priority.
- R8: `irq_o` is high exactly when both the flag and the enable bit are 1.
- R9: While the run bit is 0, the counter and both scalers hold their values and no match pulse occurs.
- R10: A write to the counter or to the control byte restarts the instruction-rate divider, the prescaler and the postscaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the selected register (combinational) |
| period_match_o | output | 1 | Unscaled one-cycle match pulse |
| irq_o | output | 1 | Interrupt request (flag AND enable) |

## Verification
The bench builds the block with its defaults: an 8-bit counter and an instruction-rate divide of 4. At these values the largest spacing (period 0xFF at divide 16) is 16384 cycles, and the full 1:16 postscale at period 0xFF is also within the run. The vector table covers every prescale select code, postscale selects 0 to 15, and periods 0, small, mid and 0xFF. For each combination it checks the first-match delay, the steady spacing and the number of matches per flag. Directed tests cover the wrap past the period, the restart of the scalers on a counter write, the hold while stopped, and the flag/enable interplay.

// File: rtl/pm_timer_pkg.sv
`timescale 1ns/1ps
package pm_timer_pkg;

    localparam int PRE_SEL_W  = 2;
    localparam int POST_SEL_W = 4;
    localparam int PRE_MAX    = 16;
    localparam int PRE_CW     = $clog2(PRE_MAX);

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_PERIOD = 2'd1,
        REG_CTRL   = 2'd2,
        REG_IRQ    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [POST_SEL_W-1:0] post_sel;
        logic                  run;
        logic [PRE_SEL_W-1:0]  pre_sel;
    } ctrl_t;

    typedef struct packed {
        logic en;
        logic flag;
    } irq_t;

    function automatic int unsigned pre_ratio(input logic [PRE_SEL_W-1:0] sel);
        case (sel)
            2'd0:    pre_ratio = 1;
            2'd1:    pre_ratio = 4;
            default: pre_ratio = 16;
        endcase
    endfunction

endpackage

// File: rtl/pmt_tick.sv
`timescale 1ns/1ps
module pmt_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick_o = run_i;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] cnt_q;

            assign tick_o = run_i && (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || clr_i) begin
                    cnt_q <= '0;
                end else if (run_i) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            // R3: divider never leaves its range
            p_div_range_r3: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= LAST);
            // R9: stopped divider holds
            p_div_hold_r9: assert property (@(posedge clk) disable iff (rst)
                (!run_i && !clr_i) |=> $stable(cnt_q));
        end
    endgenerate
endmodule

// File: rtl/pmt_prescale.sv
`timescale 1ns/1ps
module pmt_prescale
    import pm_timer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 clr_i,
    input  logic [PRE_SEL_W-1:0] sel_i,
    output logic                 inc_o
);
    logic [PRE_CW-1:0] cnt_q;
    logic [PRE_CW-1:0] last;

    always_comb begin
        last  = PRE_CW'(pre_ratio(sel_i) - 1);
        inc_o = tick_i && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
        end
    end

    // R3: prescale count stays below the selected ratio
    p_pre_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);
    // R10: a clear restarts the prescaler
    p_pre_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0);
endmodule

// File: rtl/pmt_counter.sv
`timescale 1ns/1ps
module pmt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] cnt_o,
    output logic         match_o
);
    logic [W-1:0] cnt_q;
    logic         match_q;
    logic         at_period;

    assign at_period = (cnt_q == period_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= inc_i && !wr_i && at_period;
            if (wr_i) begin
                cnt_q <= wdata_i;
            end else if (inc_i) begin
                cnt_q <= at_period ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign match_o = match_q;

    // R4: a match pulse always comes with a cleared counter
    p_match_zero_r4: assert property (@(posedge clk) disable iff (rst)
        match_q |-> cnt_q == '0);
    // R9: without an advance or a write the counter holds
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pmt_postscale.sv
`timescale 1ns/1ps
module pmt_postscale
    import pm_timer_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    input  logic                  match_i,
    input  logic [POST_SEL_W-1:0] sel_i,
    output logic                  term_o
);
    logic [POST_SEL_W-1:0] cnt_q;

    assign term_o = match_i && (cnt_q == sel_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (match_i) begin
            cnt_q <= term_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R6: postscale count never passes the selected limit
    p_post_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= sel_i);
    // R10: a clear restarts the postscaler
    p_post_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0);
endmodule

// File: rtl/pm_timer.sv
`timescale 1ns/1ps
module pm_timer
    import pm_timer_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int INSTR_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             period_match_o,
    output logic             irq_o
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int IRQ_W  = $bits(irq_t);

    reg_sel_e         sel;
    logic             wr_cnt, wr_per, wr_ctrl, wr_irq;
    logic             scale_clr;
    logic [CNT_W-1:0] period_q;
    ctrl_t            ctrl_q;
    irq_t             irq_q;
    logic             tick, inc, match, term;
    logic [CNT_W-1:0] cnt;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_cnt  = bus_wr && (sel == REG_COUNT);
    assign wr_per  = bus_wr && (sel == REG_PERIOD);
    assign wr_ctrl = bus_wr && (sel == REG_CTRL);
    assign wr_irq  = bus_wr && (sel == REG_IRQ);
    assign scale_clr = wr_cnt || wr_ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '1;
            ctrl_q   <= '0;
            irq_q    <= '0;
        end else begin
            if (wr_per)  period_q <= bus_wdata;
            if (wr_ctrl) ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_irq)  irq_q.en <= bus_wdata[1];
            if (term)        irq_q.flag <= 1'b1;
            else if (wr_irq) irq_q.flag <= bus_wdata[0];
        end
    end

    pmt_tick #(.DIV(INSTR_DIV)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .run_i (ctrl_q.run),
        .clr_i (scale_clr),
        .tick_o(tick)
    );

    pmt_prescale u_pre (
        .clk   (clk),
        .rst   (rst),
        .tick_i(tick),
        .clr_i (scale_clr),
        .sel_i (ctrl_q.pre_sel),
        .inc_o (inc)
    );

    pmt_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (inc),
        .wr_i    (wr_cnt),
        .wdata_i (bus_wdata),
        .period_i(period_q),
        .cnt_o   (cnt),
        .match_o (match)
    );

    pmt_postscale u_post (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (scale_clr),
        .match_i(match),
        .sel_i  (ctrl_q.post_sel),
        .term_o (term)
    );

    always_comb begin
        case (sel)
            REG_COUNT:  bus_rdata = cnt;
            REG_PERIOD: bus_rdata = period_q;
            REG_CTRL:   bus_rdata = CNT_W'({1'b0, ctrl_q});
            default:    bus_rdata = CNT_W'(irq_q[IRQ_W-1:0]);
        endcase
    end

    assign period_match_o = match;
    assign irq_o          = irq_q.flag && irq_q.en;

    // R9: no match pulse follows a cycle in which the timer was stopped
    p_off_nomatch_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(ctrl_q.run) |-> !match);
    // R7: the flag is cleared only through a register write
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_q.flag && !wr_irq) |=> irq_q.flag);
    // R6: a postscaler terminal count always leaves the flag set
    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        term |=> irq_q.flag);
    // R8: the request never rises without the enable bit
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> irq_q.en);
endmodule

// File: tb/pm_timer_tb.sv
`timescale 1ns/1ps
module pm_timer_tb;
    localparam int CNT_W = 8;
    localparam int DIV   = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic             period_match_o;
    logic             irq_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pm_timer #(.CNT_W(CNT_W), .INSTR_DIV(DIV)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .period_match_o(period_match_o),
        .irq_o         (irq_o)
    );

    typedef struct packed {
        logic [7:0]  per;
        logic [1:0]  pre;
        logic [3:0]  post;
        logic [15:0] first;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd3,   2'd0, 4'd0,  16'd16},
        '{8'd0,   2'd0, 4'd1,  16'd4},
        '{8'd9,   2'd1, 4'd2,  16'd160},
        '{8'd2,   2'd2, 4'd3,  16'd192},
        '{8'd2,   2'd3, 4'd0,  16'd192},
        '{8'd255, 2'd0, 4'd15, 16'd1024},
        '{8'd0,   2'd2, 4'd4,  16'd64},
        '{8'd100, 2'd1, 4'd7,  16'd1616}
    };

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        bus_addr = a;
        #0.5;
        d = int'(bus_rdata);
    endtask

    task automatic wait_match(output int n);
        n = 0;
        while (!period_match_o && n < 20000) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int v;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 counter", v, 0);
        rd(2'd1, v); check("R1 period", v, 255);
        rd(2'd2, v); check("R1 control", v, 0);
        rd(2'd3, v); check("R1 irq byte", v, 0);
        check("R1 match", int'(period_match_o), 0);
        check("R1 irq", int'(irq_o), 0);

        // table walk: R3 R4 R6 R8
        for (int i = 0; i < NV; i++) begin
            int cyc, m, since, got2;
            wr(2'd2, 8'h00);
            wr(2'd1, VECS[i].per);
            wr(2'd0, 8'h00);
            wr(2'd3, 8'h02);
            wr(2'd2, {1'b0, VECS[i].post, 1'b1, VECS[i].pre});
            wait_match(n);
            check("R3/R4 first match delay", n, int'(VECS[i].first));
            cyc = 0; m = 1; since = 0; got2 = 0;
            while (!irq_o && cyc < 40000) begin
                @(posedge clk); cyc++; since++;
                @(negedge clk);
                if (period_match_o) begin
                    m++; since = 0;
                    if (got2 == 0) begin
                        check("R4 steady spacing", cyc, int'(VECS[i].first));
                        got2 = 1;
                    end
                end
            end
            check("R6 matches per flag", m, int'(VECS[i].post) + 1);
            check("R6 flag one cycle after match", since, 1);
            rd(2'd3, v); check("R8 irq byte", v, 3);
        end

        // R9 hold while stopped
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd5);
        n = 0;
        repeat (100) begin
            @(posedge clk); @(negedge clk);
            if (period_match_o) n++;
        end
        check("R9 no match while stopped", n, 0);
        rd(2'd0, v); check("R9 counter held", v, 5);

        // R2 bit 7 of control reads 0
        wr(2'd2, 8'hFF);
        rd(2'd2, v); check("R2 control readback", v, 8'h7F);
        wr(2'd2, 8'h00);

        // R10 counter write restarts the scalers (prescale 16)
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h06);
        repeat (37) @(posedge clk);
        wr(2'd0, 8'h10);
        repeat (63) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); check("R10 no advance before 64 cycles", v, 8'h10);
        @(posedge clk); @(negedge clk);
        rd(2'd0, v); check("R10 advance at 64 cycles", v, 8'h11);

        // R5 wrap above period
        wr(2'd2, 8'h00);
        wr(2'd1, 8'd2);
        wr(2'd2, 8'h04);
        wr(2'd0, 8'd250);
        wait_match(n);
        check("R5 wrap then match", n, 36);

        // R7 / R8 flag and enable
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h04);
        repeat (20) @(posedge clk);
        wr(2'd2, 8'h00);
        rd(2'd3, v); check("R7 flag set enable off", v, 1);
        check("R8 irq low without enable", int'(irq_o), 0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        rd(2'd3, v); check("R7 flag sticky", v, 1);
        wr(2'd3, 8'h03);
        check("R8 irq high with enable", int'(irq_o), 1);
        wr(2'd3, 8'h02);
        rd(2'd3, v); check("R7 flag cleared by write", v, 2);
        check("R8 irq low after clear", int'(irq_o), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule